// File: doc/BRIEF.md
# CPU Clock Divider Pair Solver

This block picks the settings for a two-stage CPU clock path. The path multiplies a PLL-derived root clock by a fixed base of 18 over a fractional value, then divides the result by an integer. A caller supplies the root rate and the wanted CPU rate, both in kHz, and pulses `start`. The block then steps through every integer divisor candidate. For each candidate it works out the rounded fractional value and the frequency that pair actually gives. It keeps the pair whose frequency lies closest to the request.

Requests below 24000 kHz are rejected at once. A request of exactly 24000 kHz is answered with the crystal-bypass flag and no search. All divisions in the search share one iterative divider, which trades cycles for area. A full search over 63 candidates takes a few thousand cycles. The result stays on the outputs until the next accepted start.

Top module: `clkpair_solver`

## Requirements
- R1: An accepted start with `target_khz` below 24000 gives `done`=1, `fail`=1 and `use_xtal`=0 in the cycle after the start, and no search is run.
- R2: An accepted start with `target_khz` equal to 24000 gives `done`=1, `use_xtal`=1 and `fail`=0 in the cycle after the start.
- R3: In every other case the integer divisor candidate c runs from 1 up to 63 (2^DIV_W-1). For each c the fractional value is f = floor((floor(root*18/c) + floor(target/2)) / target). On success `frac_sel` reports f and `idiv_sel` reports c.
- R4: The frequency a candidate achieves is floor(root*18/(f*c)), and its error is that value minus the target. The chosen candidate has the smallest absolute error. On a tie, the lowest c is kept.
- R5: A candidate whose f lies outside 18..35 is discarded. If every candidate is discarded, `fail`=1.
- R6: If the best absolute error is above 100 kHz, `fail`=1.
- R7: The search stops at the first candidate with zero error. For a request met exactly at c=1, `done` arrives within 4*(NUM_W+2) cycles of the start, where NUM_W=KHZ_W+5.
- R8: `done` is a one-cycle pulse. `busy` is 1 from the cycle after an accepted search start until `done`, and 0 while `done` is 1. On fail or bypass, `frac_sel` and `idiv_sel` are 0. `fail` and `use_xtal` are never both 1.
- R9: A `start` while `busy`=1 is ignored, and the running search finishes on its original operands.
- R10: While idle and without `start`, the outputs `frac_sel`, `idiv_sel`, `fail` and `use_xtal` hold their values.
- R11: After reset, `busy`, `done`, `fail`, `use_xtal`, `frac_sel` and `idiv_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a solve; sampled only when idle |
| root_khz | input | KHZ_W (20) | Root PLL rate in kHz |
| target_khz | input | KHZ_W (20) | Requested CPU rate in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No acceptable pair, or request too low |
| use_xtal | output | 1 | Request served by the crystal bypass |
| frac_sel | output | FRAC_W (6) | Chosen fractional value |
| idiv_sel | output | DIV_W (6) | Chosen integer divisor |

## Verification
The bench builds the block with its default parameters: 20-bit kHz operands, a 6-bit divisor field, a fractional window of 18..35 and a 100 kHz tolerance. With these values, real PLL rates such as 480 MHz can be solved across the full 63-candidate sweep. The bench sweeps target rates across that range and compares each result against an arithmetic model of the requirements. It also drives the reject, bypass, out-of-window and out-of-tolerance cases, an exact-match early stop, and a start issued during a search.

// File: rtl/clkpair_pkg.sv
// Shared types for the divider pair solver.
package clkpair_pkg;
    // Controller states: launch/wait pairs for the three divisions of one candidate
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1,
        ST_W1,
        ST_L2,
        ST_W2,
        ST_L3,
        ST_W3,
        ST_STEP
    } solve_state_t;
endpackage

// File: rtl/clkpair_divider.sv
// Iterative restoring unsigned divider, one quotient bit per cycle.
// Assumes den is nonzero whenever start is raised; ready pulses W+1 cycles
// after start with the quotient on quo. A new start restarts the unit.
module clkpair_divider #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         ready
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  qsh;
    logic [W-1:0]  den_r;
    logic [CW-1:0] cnt;
    logic          running;
    logic [W:0]    trial;
    logic          fits;

    // Shift the next dividend bit into the partial remainder and test it
    always_comb begin
        trial = {rem, qsh[W-1]};
        fits  = trial >= {1'b0, den_r};
    end

    // Load operands on start, then resolve one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            qsh     <= '0;
            den_r   <= '0;
            cnt     <= '0;
            running <= 1'b0;
            ready   <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (start) begin
                rem     <= '0;
                qsh     <= num;
                den_r   <= den;
                cnt     <= CW'(W);
                running <= 1'b1;
            end else if (running) begin
                rem <= fits ? W'(trial - {1'b0, den_r}) : trial[W-1:0];
                qsh <= {qsh[W-2:0], fits};
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    running <= 1'b0;
                    ready   <= 1'b1;
                end
            end
        end
    end

    assign quo = qsh;
endmodule

// File: rtl/clkpair_judge.sv
// Combinational scoring of one candidate: fractional window test,
// absolute frequency error and comparison against the best so far.
// Assumes achieved and frac_q are the divider results of the current candidate.
module clkpair_judge #(
    parameter int KHZ_W    = 20,
    parameter int NUM_W    = 25,
    parameter int FRAC_MIN = 18,
    parameter int FRAC_MAX = 35
) (
    input  logic [NUM_W-1:0] frac_q,
    input  logic [NUM_W-1:0] achieved,
    input  logic [KHZ_W-1:0] target,
    input  logic [NUM_W-1:0] best_abs,
    input  logic             best_valid,
    output logic             in_range,
    output logic [NUM_W-1:0] abs_err,
    output logic             better
);
    localparam logic [NUM_W-1:0] LO = NUM_W'(FRAC_MIN);
    localparam logic [NUM_W-1:0] HI = NUM_W'(FRAC_MAX);

    logic [NUM_W-1:0] tgt_x;

    // Window test, magnitude of error, strict improvement (first wins ties)
    always_comb begin
        tgt_x    = NUM_W'(target);
        in_range = (frac_q >= LO) && (frac_q <= HI);
        abs_err  = (achieved >= tgt_x) ? (achieved - tgt_x) : (tgt_x - achieved);
        better   = !best_valid || (abs_err < best_abs);
    end
endmodule

// File: rtl/clkpair_ctrl.sv
// Search controller: screens the request, walks the integer divisor
// candidates, sequences the shared divider and keeps the best pair.
// Assumes the divider returns ready exactly once per launch.
module clkpair_ctrl
    import clkpair_pkg::*;
#(
    parameter int KHZ_W     = 20,
    parameter int DIV_W     = 6,
    parameter int NUM_W     = 25,
    parameter int FRAC_W    = 6,
    parameter int FRAC_BASE = 18,
    parameter int TOL_KHZ   = 100,
    parameter int XTAL_KHZ  = 24000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KHZ_W-1:0]  root_khz,
    input  logic [KHZ_W-1:0]  target_khz,
    input  logic [NUM_W-1:0]  div_quo,
    input  logic              div_ready,
    input  logic              in_range,
    input  logic [NUM_W-1:0]  abs_err,
    input  logic              better,
    output logic              div_start,
    output logic [NUM_W-1:0]  div_num,
    output logic [NUM_W-1:0]  div_den,
    output logic [NUM_W-1:0]  frac_q,
    output logic [KHZ_W-1:0]  tgt_q,
    output logic [NUM_W-1:0]  best_abs,
    output logic              best_valid,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              use_xtal,
    output logic [FRAC_W-1:0] frac_sel,
    output logic [DIV_W-1:0]  idiv_sel
);
    localparam logic [KHZ_W-1:0] XTAL_K = KHZ_W'(XTAL_KHZ);
    localparam logic [NUM_W-1:0] TOL_K  = NUM_W'(TOL_KHZ);
    localparam logic [NUM_W-1:0] BASE_K = NUM_W'(FRAC_BASE);

    solve_state_t     state;
    logic [DIV_W-1:0] cand;
    logic [NUM_W-1:0] prod;
    logic [NUM_W-1:0] q1_r;
    logic [FRAC_W-1:0] best_f;
    logic [DIV_W-1:0] best_c;
    logic             finish;
    logic             ok;

    // Divider operand selection for the phase being launched
    always_comb begin
        div_start = 1'b0;
        div_num   = prod;
        div_den   = NUM_W'(cand);
        unique case (state)
            ST_L1: div_start = 1'b1;
            ST_L2: begin
                div_start = 1'b1;
                div_num   = q1_r + NUM_W'(tgt_q >> 1);
                div_den   = NUM_W'(tgt_q);
            end
            ST_L3: begin
                div_start = in_range;
                div_den   = NUM_W'(frac_q[FRAC_W-1:0]) * NUM_W'(cand);
            end
            default: ;
        endcase
    end

    // End of sweep: last candidate reached or an exact pair already found
    always_comb begin
        finish = (cand == '1) || (best_valid && best_abs == '0);
        ok     = best_valid && (best_abs <= TOL_K);
    end

    // Main sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cand       <= '0;
            prod       <= '0;
            q1_r       <= '0;
            frac_q     <= '0;
            tgt_q      <= '0;
            best_abs   <= '0;
            best_valid <= 1'b0;
            best_f     <= '0;
            best_c     <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            fail       <= 1'b0;
            use_xtal   <= 1'b0;
            frac_sel   <= '0;
            idiv_sel   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        tgt_q    <= target_khz;
                        frac_sel <= '0;
                        idiv_sel <= '0;
                        if (target_khz < XTAL_K) begin
                            fail     <= 1'b1;
                            use_xtal <= 1'b0;
                            done     <= 1'b1;
                        end else if (target_khz == XTAL_K) begin
                            fail     <= 1'b0;
                            use_xtal <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            fail       <= 1'b0;
                            use_xtal   <= 1'b0;
                            busy       <= 1'b1;
                            cand       <= DIV_W'(1);
                            best_valid <= 1'b0;
                            best_abs   <= '0;
                            prod       <= NUM_W'(root_khz) * BASE_K;
                            state      <= ST_L1;
                        end
                    end
                end
                ST_L1: state <= ST_W1;
                ST_W1: if (div_ready) begin
                    q1_r  <= div_quo;
                    state <= ST_L2;
                end
                ST_L2: state <= ST_W2;
                ST_W2: if (div_ready) begin
                    frac_q <= div_quo;
                    state  <= ST_L3;
                end
                ST_L3: state <= in_range ? ST_W3 : ST_STEP;
                ST_W3: if (div_ready) begin
                    if (better) begin
                        best_abs   <= abs_err;
                        best_valid <= 1'b1;
                        best_f     <= frac_q[FRAC_W-1:0];
                        best_c     <= cand;
                    end
                    state <= ST_STEP;
                end
                ST_STEP: begin
                    if (finish) begin
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        fail     <= !ok;
                        frac_sel <= ok ? best_f : '0;
                        idiv_sel <= ok ? best_c : '0;
                        state    <= ST_IDLE;
                    end else begin
                        cand  <= cand + DIV_W'(1);
                        state <= ST_L1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clkpair_solver.sv
// Top of the divider pair solver: controller, shared iterative divider
// and candidate scorer. Rates are in kHz; one solve per start pulse.
module clkpair_solver #(
    parameter int KHZ_W     = 20,
    parameter int DIV_W     = 6,
    parameter int FRAC_BASE = 18,
    parameter int FRAC_MIN  = 18,
    parameter int FRAC_MAX  = 35,
    parameter int TOL_KHZ   = 100,
    parameter int XTAL_KHZ  = 24000,
    localparam int FRAC_W   = $clog2(FRAC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KHZ_W-1:0]  root_khz,
    input  logic [KHZ_W-1:0]  target_khz,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              use_xtal,
    output logic [FRAC_W-1:0] frac_sel,
    output logic [DIV_W-1:0]  idiv_sel
);
    localparam int NUM_W = KHZ_W + $clog2(FRAC_BASE + 1);

    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic [NUM_W-1:0] div_den;
    logic [NUM_W-1:0] div_quo;
    logic             div_ready;
    logic [NUM_W-1:0] frac_q;
    logic [KHZ_W-1:0] tgt_q;
    logic [NUM_W-1:0] best_abs;
    logic             best_valid;
    logic             in_range;
    logic [NUM_W-1:0] abs_err;
    logic             better;

    clkpair_divider #(.W(NUM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .ready (div_ready)
    );

    clkpair_judge #(
        .KHZ_W(KHZ_W), .NUM_W(NUM_W), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX)
    ) u_judge (
        .frac_q     (frac_q),
        .achieved   (div_quo),
        .target     (tgt_q),
        .best_abs   (best_abs),
        .best_valid (best_valid),
        .in_range   (in_range),
        .abs_err    (abs_err),
        .better     (better)
    );

    clkpair_ctrl #(
        .KHZ_W(KHZ_W), .DIV_W(DIV_W), .NUM_W(NUM_W), .FRAC_W(FRAC_W),
        .FRAC_BASE(FRAC_BASE), .TOL_KHZ(TOL_KHZ), .XTAL_KHZ(XTAL_KHZ)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .root_khz   (root_khz),
        .target_khz (target_khz),
        .div_quo    (div_quo),
        .div_ready  (div_ready),
        .in_range   (in_range),
        .abs_err    (abs_err),
        .better     (better),
        .div_start  (div_start),
        .div_num    (div_num),
        .div_den    (div_den),
        .frac_q     (frac_q),
        .tgt_q      (tgt_q),
        .best_abs   (best_abs),
        .best_valid (best_valid),
        .busy       (busy),
        .done       (done),
        .fail       (fail),
        .use_xtal   (use_xtal),
        .frac_sel   (frac_sel),
        .idiv_sel   (idiv_sel)
    );
endmodule

// File: rtl/clkpair_solver_chk.sv
// Port-level protocol and result checks for clkpair_solver, bound to every instance.
module clkpair_solver_chk #(
    parameter int KHZ_W    = 20,
    parameter int DIV_W    = 6,
    parameter int FRAC_MIN = 18,
    parameter int FRAC_MAX = 35,
    parameter int XTAL_KHZ = 24000,
    localparam int FRAC_W  = $clog2(FRAC_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [KHZ_W-1:0]  target_khz,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              use_xtal,
    input logic [FRAC_W-1:0] frac_sel,
    input logic [DIV_W-1:0]  idiv_sel
);
    localparam logic [KHZ_W-1:0]  XK = KHZ_W'(XTAL_KHZ);
    localparam logic [FRAC_W-1:0] FL = FRAC_W'(FRAC_MIN);
    localparam logic [FRAC_W-1:0] FH = FRAC_W'(FRAC_MAX);

    assert_low_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && target_khz < XK) |=> (done && fail && !use_xtal));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && target_khz == XK) |=> (done && use_xtal && !fail));

    assert_frac_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && !use_xtal) |-> (frac_sel >= FL && frac_sel <= FH && idiv_sel != '0));

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(use_xtal && fail));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_zero_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (fail || use_xtal)) |-> (frac_sel == '0 && idiv_sel == '0));

    assert_busy_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || ($stable(frac_sel) && $stable(idiv_sel) && $stable(fail) && $stable(use_xtal))));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(frac_sel) && $stable(idiv_sel) && $stable(fail) && $stable(use_xtal)));
endmodule

bind clkpair_solver clkpair_solver_chk #(
    .KHZ_W(KHZ_W), .DIV_W(DIV_W), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX), .XTAL_KHZ(XTAL_KHZ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .target_khz (target_khz),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .use_xtal   (use_xtal),
    .frac_sel   (frac_sel),
    .idiv_sel   (idiv_sel)
);

// File: tb/clkpair_solver_test.sv
// Self-checking bench: arithmetic model of the requirements, sweeps of target rates.
module clkpair_solver_test;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ_W      = 20;
    localparam int DIV_W      = 6;
    localparam int FRAC_W     = 6;
    localparam int NUM_W      = KHZ_W + 5;
    localparam int WATCHDOG   = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [KHZ_W-1:0]  root_khz = '0;
    logic [KHZ_W-1:0]  target_khz = '0;
    logic              busy, done, fail, use_xtal;
    logic [FRAC_W-1:0] frac_sel;
    logic [DIV_W-1:0]  idiv_sel;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    clkpair_solver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .root_khz(root_khz),
        .target_khz(target_khz), .busy(busy), .done(done), .fail(fail),
        .use_xtal(use_xtal), .frac_sel(frac_sel), .idiv_sel(idiv_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: an expired run counts as one failed check
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected below)", WATCHDOG, cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Arithmetic model of R1..R6
    task automatic model(input longint root, input longint tgt,
                         output bit m_fail, output bit m_xtal,
                         output longint m_f, output longint m_c);
        longint best;
        bit     found;
        m_fail = 0; m_xtal = 0; m_f = 0; m_c = 0;
        best = 0; found = 0;
        if (tgt < 24000) begin
            m_fail = 1;
        end else if (tgt == 24000) begin
            m_xtal = 1;
        end else begin
            for (longint c = 1; c < 64; c++) begin
                longint q1, f, ach, e;
                q1 = (root * 18) / c;
                f  = (q1 + tgt / 2) / tgt;
                if (f < 18 || f > 35) continue;
                ach = (root * 18) / (f * c);
                e = ach - tgt;
                if (e < 0) e = -e;
                if (!found || e < best) begin
                    best = e; found = 1; m_f = f; m_c = c;
                end
                if (e == 0) break;
            end
            if (!found || best > 100) begin
                m_fail = 1; m_f = 0; m_c = 0;
            end
        end
    endtask

    task automatic pulse_start(input longint root, input longint tgt);
        @(negedge clk);
        root_khz   = KHZ_W'(root);
        target_khz = KHZ_W'(tgt);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    // Waits for done; cycles counts edges from the start edge to done visible
    task automatic wait_done(output int cycles);
        cycles = 1;
        while (!done && cycles < 8000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic solve_check(input longint root, input longint tgt, input string req);
        bit m_fail, m_xtal;
        longint m_f, m_c;
        int cycles;
        model(root, tgt, m_fail, m_xtal, m_f, m_c);
        pulse_start(root, tgt);
        wait_done(cycles);
        chk(done == 1'b1, {req, " done seen"}, done, 1);
        chk(fail == m_fail, {req, " fail flag"}, fail, m_fail);
        chk(use_xtal == m_xtal, {req, " bypass flag"}, use_xtal, m_xtal);
        chk(frac_sel == FRAC_W'(m_f), {req, " frac_sel"}, frac_sel, m_f);
        chk(idiv_sel == DIV_W'(m_c), {req, " idiv_sel"}, idiv_sel, m_c);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single pulse", done, 0);
    endtask

    initial begin
        int cycles;
        bit m_fail, m_xtal;
        longint m_f, m_c;
        logic [FRAC_W-1:0] hold_f;
        logic [DIV_W-1:0]  hold_c;
        logic              hold_fail;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy == 0 && done == 0, "R11 busy/done after reset", {busy, done}, 0);
        chk(fail == 0 && use_xtal == 0, "R11 flags after reset", {fail, use_xtal}, 0);
        chk(frac_sel == 0 && idiv_sel == 0, "R11 selectors after reset", {frac_sel, idiv_sel}, 0);
        rst_n = 1'b1;

        // R1: reject below the crystal rate, result the cycle after start
        pulse_start(480000, 23999);
        chk(done && fail && !use_xtal, "R1 reject 23999", {done, fail, use_xtal}, 3'b110);
        chk(frac_sel == 0 && idiv_sel == 0, "R8 zeros on reject", {frac_sel, idiv_sel}, 0);
        pulse_start(480000, 0);
        chk(done && fail, "R1 reject zero", {done, fail}, 2'b11);

        // R2: bypass at exactly the crystal rate
        pulse_start(480000, 24000);
        chk(done && use_xtal && !fail, "R2 bypass", {done, use_xtal, fail}, 3'b110);
        chk(frac_sel == 0 && idiv_sel == 0, "R8 zeros on bypass", {frac_sel, idiv_sel}, 0);

        // R7: exact hit at c=1 stops early
        pulse_start(480000, 480000);
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy during search", busy, 1);
        wait_done(cycles);
        cycles++;
        chk(cycles <= 4 * (NUM_W + 2), "R7 early stop latency", cycles, 4 * (NUM_W + 2));
        chk(frac_sel == 18 && idiv_sel == 1 && !fail, "R7 exact pair", {frac_sel, idiv_sel}, {6'd18, 6'd1});
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);

        // R5: every candidate outside the window
        solve_check(480000, 700000, "R5");
        // R6: only in-window candidate misses by over 100 kHz
        solve_check(100000, 61001, "R6");
        solve_check(100000, 58500, "R6");

        // R3/R4 sweep over the target range from a 480 MHz root
        for (int k = 0; k < 12; k++) solve_check(480000, 24001 + k * 41017, "R4");
        // R3 sweep from a different root
        for (int k = 0; k < 5; k++) solve_check(320000, 150000 + k * 33333, "R3");
        solve_check(480000, 261818, "R4");

        // R9: a start during a search is ignored
        model(480000, 360000, m_fail, m_xtal, m_f, m_c);
        pulse_start(480000, 360000);
        repeat (10) @(negedge clk);
        root_khz = KHZ_W'(100000); target_khz = KHZ_W'(23999); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0 && fail == 1'b0, "R9 mid-search start ignored", {done, fail}, 0);
        wait_done(cycles);
        chk(fail == m_fail && frac_sel == FRAC_W'(m_f) && idiv_sel == DIV_W'(m_c), "R9 original operands",
            {fail, frac_sel, idiv_sel}, {m_fail, 6'(m_f), 6'(m_c)});

        // R10: outputs hold while idle, even as inputs change
        hold_f = frac_sel; hold_c = idiv_sel; hold_fail = fail;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            root_khz = KHZ_W'(k * 777); target_khz = KHZ_W'(k * 1234);
        end
        chk(frac_sel == hold_f && idiv_sel == hold_c && fail == hold_fail && !use_xtal,
            "R10 hold while idle", {frac_sel, idiv_sel}, {hold_f, hold_c});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule